// File: doc/BRIEF.md
# Logical-to-Physical Bank Translator

This block widens a 16-bit processor logical address into a 20-bit physical address. The logical space is cut into 4 KB pages. Pages at or above a programmable common start form the common area. Pages from a programmable bank start up to the common start form the banked area. Pages below the bank start pass through unchanged. The banked and common areas each have an 8-bit physical base register, counted in 4 KB units, and this base is added to the logical address.

Software programs the three registers through a small synchronous I/O write port. The translation itself is purely combinational. A DMA master can raise a bypass enable and supply a full 20-bit physical address, which goes straight to the output without any mapping. Physical memory that the common window hides from the processor is still reachable this way.

Top module: `bank_xlat`

## Requirements
- R1: While reset is asserted and after it is released, the bank base and common base are 0x00 and the boundary is 0xF0, so physical = zero-extended logical (identity over 0x00000–0x0FFFF).
- R2: With bypass off, phys_addr_o[11:0] always equals log_addr_i[11:0].
- R3: If log_addr_i[15:12] >= bank start and < common start, phys_addr_o = (log_addr_i + bank_base*0x1000) mod 2^20.
- R4: If log_addr_i[15:12] >= common start, phys_addr_o = (log_addr_i + com_base*0x1000) mod 2^20. The common area takes priority when it overlaps the bank start.
- R5: If log_addr_i[15:12] is below both the bank start and the common start, phys_addr_o = {4'h0, log_addr_i}.
- R6: io_sel_i picks the register: 0 bank base, 1 common base, 2 boundary (bits 7:4 common start page, bits 3:0 bank start page). A write with select 3 changes nothing.
- R7: A write takes effect at the rising clock edge where io_we_i is high. Before that edge the output still uses the old value.
- R8: With dma_en_i high, phys_addr_o = dma_addr_i whatever the logical address and the registers hold.
- R9: With io_we_i low, changes on io_sel_i and io_wdata_i leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_we_i | input | 1 | Register write strobe |
| io_sel_i | input | 2 | Register select |
| io_wdata_i | input | 8 | Register write data |
| log_addr_i | input | 16 | Processor logical address |
| dma_en_i | input | 1 | Bypass enable for DMA physical addressing |
| dma_addr_i | input | 20 | DMA physical address |
| phys_addr_o | output | 20 | Physical address |

## Verification
The bench uses the default parameters: a 16-bit logical space, a 20-bit physical space, 4 KB pages and 8-bit bases. With these values every one of the 16 bank-start and common-start settings can be programmed, including settings where the two fields cross. Bases near 0xFF let the sum pass 1 MB, so the wrap at 20 bits is exercised. The common window can be placed on any page boundary, so the physical pages it hides can be compared between the mapped path and the DMA bypass.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_BANK  = 2'd0,
    SEL_COM   = 2'd1,
    SEL_BOUND = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
  typedef enum logic [1:0] {
    AREA_LOW  = 2'd0,
    AREA_BANK = 2'd1,
    AREA_COM  = 2'd2
  } area_e;
  localparam int NREG = 3;
endpackage

// File: rtl/bank_xlat_regs.sv
module bank_xlat_regs
  import bank_xlat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BASE_W = 8,
  parameter int PG_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BASE_W-1:0] bank_base_o,
  output logic [BASE_W-1:0] com_base_o,
  output logic [DATA_W-1:0] bound_o
);
  localparam logic [DATA_W-1:0] BOUND_RST = DATA_W'({{PG_W{1'b1}}, {PG_W{1'b0}}});

  logic [DATA_W-1:0] reg_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST = (i == int'(SEL_BOUND)) ? BOUND_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               reg_q[i] <= RST;
      else if (we_i && (sel_i == SEL_W'(i)))     reg_q[i] <= wdata_i;
    end
  end

  assign bank_base_o = reg_q[SEL_BANK][BASE_W-1:0];
  assign com_base_o  = reg_q[SEL_COM][BASE_W-1:0];
  assign bound_o     = reg_q[SEL_BOUND];
endmodule

// File: rtl/bank_xlat_decode.sv
module bank_xlat_decode
  import bank_xlat_pkg::*;
#(
  parameter int PG_W = 4
) (
  input  logic [PG_W-1:0] page_i,
  input  logic [PG_W-1:0] bank_start_i,
  input  logic [PG_W-1:0] com_start_i,
  output area_e           area_o
);
  // common wins when the two fields overlap
  always_comb begin
    if (page_i >= com_start_i)       area_o = AREA_COM;
    else if (page_i >= bank_start_i) area_o = AREA_BANK;
    else                             area_o = AREA_LOW;
  end
endmodule

// File: rtl/bank_xlat_add.sv
module bank_xlat_add
  import bank_xlat_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int PAGE_W = 12,
  parameter int BASE_W = 8
) (
  input  logic [LOG_W-1:0]  log_addr_i,
  input  area_e             area_i,
  input  logic [BASE_W-1:0] bank_base_i,
  input  logic [BASE_W-1:0] com_base_i,
  output logic [PHYS_W-1:0] phys_addr_o
);
  localparam int SUM_W = BASE_W + PAGE_W;

  logic [BASE_W-1:0] base;
  logic [SUM_W-1:0]  offset;

  always_comb begin
    unique case (area_i)
      AREA_BANK: base = bank_base_i;
      AREA_COM:  base = com_base_i;
      default:   base = '0;
    endcase
  end

  assign offset      = {base, {PAGE_W{1'b0}}};
  // modulo 2^PHYS_W wrap is intended
  assign phys_addr_o = PHYS_W'({{(PHYS_W-LOG_W){1'b0}}, log_addr_i}) + PHYS_W'(offset);
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bank_xlat_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int PAGE_W = 12,
  parameter int BASE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_we_i,
  input  logic [1:0]        io_sel_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic [LOG_W-1:0]  log_addr_i,
  input  logic              dma_en_i,
  input  logic [PHYS_W-1:0] dma_addr_i,
  output logic [PHYS_W-1:0] phys_addr_o
);
  localparam int PG_W = LOG_W - PAGE_W;

  logic [BASE_W-1:0] bank_base;
  logic [BASE_W-1:0] com_base;
  logic [DATA_W-1:0] bound;
  area_e             area;
  logic [PHYS_W-1:0] xlat_addr;

  bank_xlat_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W), .PG_W(PG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (io_we_i),
    .sel_i      (io_sel_i),
    .wdata_i    (io_wdata_i),
    .bank_base_o(bank_base),
    .com_base_o (com_base),
    .bound_o    (bound)
  );

  bank_xlat_decode #(.PG_W(PG_W)) u_dec (
    .page_i      (log_addr_i[LOG_W-1:PAGE_W]),
    .bank_start_i(bound[PG_W-1:0]),
    .com_start_i (bound[2*PG_W-1:PG_W]),
    .area_o      (area)
  );

  bank_xlat_add #(
    .LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W)
  ) u_add (
    .log_addr_i (log_addr_i),
    .area_i     (area),
    .bank_base_i(bank_base),
    .com_base_i (com_base),
    .phys_addr_o(xlat_addr)
  );

  assign phys_addr_o = dma_en_i ? dma_addr_i : xlat_addr;
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 20,
  parameter int PAGE_W = 12,
  parameter int BASE_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_we_i,
  input logic [1:0]        io_sel_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic [LOG_W-1:0]  log_addr_i,
  input logic              dma_en_i,
  input logic [PHYS_W-1:0] dma_addr_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [BASE_W-1:0] bank_base,
  input logic [BASE_W-1:0] com_base,
  input logic [DATA_W-1:0] bound
);
  localparam int PG_W = LOG_W - PAGE_W;

  logic            seen_q;
  logic [PG_W-1:0] page, b_start, c_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign page    = log_addr_i[LOG_W-1:PAGE_W];
  assign b_start = bound[PG_W-1:0];
  assign c_start = bound[2*PG_W-1:PG_W];

  assert_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> phys_addr_o[PAGE_W-1:0] == log_addr_i[PAGE_W-1:0]);

  assert_low_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_i && page < b_start && page < c_start)
      |-> phys_addr_o == {{(PHYS_W-LOG_W){1'b0}}, log_addr_i});

  assert_sel_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_sel_i == 2'd3)
      |=> ($stable(bank_base) && $stable(com_base) && $stable(bound)));

  assert_bank_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_sel_i == 2'd0) |=> bank_base == $past(io_wdata_i[BASE_W-1:0]));

  assert_bound_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_we_i && io_sel_i == 2'd2) |=> bound == $past(io_wdata_i));

  assert_dma_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i |-> phys_addr_o == dma_addr_i);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(io_we_i))
      |-> ($stable(bank_base) && $stable(com_base) && $stable(bound)));
endmodule

bind bank_xlat bank_xlat_chk #(
  .LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_we_i    (io_we_i),
  .io_sel_i   (io_sel_i),
  .io_wdata_i (io_wdata_i),
  .log_addr_i (log_addr_i),
  .dma_en_i   (dma_en_i),
  .dma_addr_i (dma_addr_i),
  .phys_addr_o(phys_addr_o),
  .bank_base  (bank_base),
  .com_base   (com_base),
  .bound      (bound)
);

// File: tb/sim_bank_xlat.sv
`timescale 1ns/1ps
module sim_bank_xlat;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_we_i = 1'b0;
  logic [1:0]  io_sel_i = 2'd0;
  logic [7:0]  io_wdata_i = 8'h00;
  logic [15:0] log_addr_i = 16'h0000;
  logic        dma_en_i = 1'b0;
  logic [19:0] dma_addr_i = 20'h00000;
  logic [19:0] phys_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  bank_xlat u0 (.*);

  // fields: boundary, bank base, common base, logical, expected physical
  localparam int NVEC = 14;
  localparam logic [59:0] VEC [NVEC] = '{
    {8'hF0, 8'h00, 8'h00, 16'h1234, 20'h01234},
    {8'hF0, 8'h10, 8'h00, 16'h1234, 20'h11234},
    {8'hF0, 8'h10, 8'h00, 16'hF123, 20'h0F123},
    {8'hF0, 8'h10, 8'h00, 16'hEFFF, 20'h1EFFF},
    {8'hE4, 8'h20, 8'h30, 16'h3FFF, 20'h03FFF},
    {8'hE4, 8'h20, 8'h30, 16'h4000, 20'h24000},
    {8'hE4, 8'h20, 8'h30, 16'hE000, 20'h3E000},
    {8'hF0, 8'hF8, 8'h00, 16'h9000, 20'h01000},
    {8'h80, 8'h00, 8'hF8, 16'h8ABC, 20'h00ABC},
    {8'h4C, 8'h11, 8'h22, 16'h5000, 20'h27000},
    {8'h4C, 8'h11, 8'h22, 16'h3000, 20'h03000},
    {8'h00, 8'h55, 8'h77, 16'h0000, 20'h77000},
    {8'hFF, 8'h40, 8'h00, 16'hEFFF, 20'h0EFFF},
    {8'hFF, 8'h40, 8'h09, 16'hF001, 20'h18001}
  };

  function automatic logic [19:0] ref_map(input logic [7:0] bnd, input logic [7:0] bb,
                                          input logic [7:0] cb, input logic [15:0] la);
    logic [7:0] base;
    if (la[15:12] >= bnd[7:4])      base = cb;
    else if (la[15:12] >= bnd[3:0]) base = bb;
    else                            base = 8'h00;
    return {4'h0, la} + {base, 12'h000};
  endfunction

  function automatic string area_tag(input logic [7:0] bnd, input logic [15:0] la);
    if (la[15:12] >= bnd[7:4])      return "R4";
    else if (la[15:12] >= bnd[3:0]) return "R3";
    else                            return "R5";
  endfunction

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%05h exp=%05h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk_i);
    io_we_i = 1'b1; io_sel_i = sel; io_wdata_i = data;
    @(negedge clk_i);
    io_we_i = 1'b0;
  endtask

  task automatic program_map(input logic [7:0] bnd, input logic [7:0] bb, input logic [7:0] cb);
    wr(2'd2, bnd); wr(2'd0, bb); wr(2'd1, cb);
  endtask

  task automatic probe(input string req, input logic [15:0] la, input logic [19:0] exp);
    log_addr_i = la;
    #2;
    check(req, phys_addr_o, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, both during and after reset
    probe("R1", 16'hABCD, 20'h0ABCD);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R1", 16'h0000, 20'h00000);
    probe("R1", 16'hF123, 20'h0F123);
    probe("R1", 16'hFFFF, 20'h0FFFF);

    // table walk: R3, R4, R5, R2
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] bnd, bb, cb; logic [15:0] la; logic [19:0] ex;
      {bnd, bb, cb, la, ex} = VEC[i];
      program_map(bnd, bb, cb);
      probe(area_tag(bnd, la), la, ex);
      check("R2", {8'h00, phys_addr_o[11:0]}, {8'h00, la[11:0]});
    end

    // R6: select 3 ignored; mapping from F0/20/05
    program_map(8'hF0, 8'h20, 8'h05);
    wr(2'd3, 8'h0F);
    probe("R6", 16'h1234, 20'h21234);
    probe("R6", 16'hF234, 20'h14234);

    // R9: sel/data toggling with write strobe low
    @(negedge clk_i);
    io_sel_i = 2'd2; io_wdata_i = 8'h00;
    @(negedge clk_i);
    io_sel_i = 2'd0; io_wdata_i = 8'h99;
    @(negedge clk_i);
    probe("R9", 16'h1234, 20'h21234);
    probe("R9", 16'hF234, 20'h14234);

    // R7: old value before the edge, new value after
    @(negedge clk_i);
    log_addr_i = 16'h5000;
    io_we_i = 1'b1; io_sel_i = 2'd0; io_wdata_i = 8'h33;
    #2 check("R7", phys_addr_o, 20'h25000);
    @(posedge clk_i);
    #2 check("R7", phys_addr_o, 20'h38000);
    @(negedge clk_i);
    io_we_i = 1'b0;

    // R8: bypass, including a page hidden by the common window
    program_map(8'hF0, 8'h20, 8'h00);
    probe("R4", 16'hF456, 20'h0F456);
    dma_en_i = 1'b1; dma_addr_i = 20'h2F456;
    probe("R8", 16'hF456, 20'h2F456);
    dma_addr_i = 20'h7F123;
    probe("R8", 16'h0001, 20'h7F123);
    dma_en_i = 1'b0;
    probe("R3", 16'h0001, 20'h20001);

    // randomized settings against the reference model
    for (int n = 0; n < 200; n++) begin
      logic [7:0] bnd, bb, cb;
      bnd = 8'($urandom); bb = 8'($urandom); cb = 8'($urandom);
      program_map(bnd, bb, cb);
      for (int k = 0; k < 4; k++) begin
        logic [15:0] la;
        la = 16'($urandom);
        probe(area_tag(bnd, la), la, ref_map(bnd, bb, cb, la));
      end
    end

    // R1: reset again after programming
    @(negedge clk_i);
    rst_ni = 1'b0;
    probe("R1", 16'h8765, 20'h08765);
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R1", 16'hE001, 20'h0E001);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule